// File: doc/BRIEF.md
# Peripheral Adapter Register Bank

This block is the register side of a classic 8-bit peripheral interface adapter. A host reaches it through a 4-bit register select and an 8-bit data bus. It holds:

- two parallel ports, each with its own direction register;
- the auxiliary and peripheral control bytes;
- a shift data byte;
- the timer latches;
- the interrupt flag and enable bytes, which drive one active-high interrupt line.

The timer counters sit outside the block. It reads their live values from input buses. When a high byte is written, it emits a one-cycle load strobe with the full 16-bit start value. Interrupt sources outside the block raise flags through per-bit set strobes.

Port B feeds a small attached controller. A write to port B changes only the bits that its direction register marks as outputs. The updated port value goes to the controller only when the direction bits for the handshake lines carry the expected pattern. This keeps host software that pokes input pins from corrupting the handshake.

Top module: `via_regfile`

## Requirements
- R1: After reset the following read zero: both ports, both direction bytes, the auxiliary and peripheral control bytes, the flag byte and the enable byte (enable reads 0x80). The timer 1 low latch (select 6) and high latch (select 7) read 0xFF. The timer 2 low latch is 0xFF, which shows as the low byte of the first timer 2 load value.
- R2: Selects 1 and 15 read and write the same port A byte.
- R3: A write to select 0 (port B) replaces only the bits whose port B direction bit is 1. Bits set as inputs keep their value. Select 0 reads back the whole port B byte.
- R4: Select 14 reads the enable byte with bit 7 forced to 1. A write with data bit 7 = 1 sets the enable bits marked by 1s in data bits 6..0. A write with data bit 7 = 0 clears them.
- R5: A write to select 13 clears every flag whose data bit (6..0) is 1 and leaves the others.
- R6: Select 10 stores the shift byte on write and returns it on read. Either access clears flag bit 2.
- R7: Select 4 reads the low byte of the timer 1 count and clears flag bit 6. Select 5 reads the high byte. Select 8 reads the low byte of the timer 2 count and clears flag bit 5. Select 9 reads the timer 2 high byte.
- R8: A write to select 4 or 6 sets the timer 1 low latch, and a write to select 7 sets the high latch. A write to select 5 sets the high latch, pulses the timer 1 load strobe with {data, low latch} and clears flag bit 6. A write to select 8 sets the timer 2 low latch. A write to select 9 pulses the timer 2 load strobe with {data, timer 2 low latch} and clears flag bit 5.
- R9: Select 13 reads the flags in bits 6..0. Bit 7 reads 1 exactly when some flag is set whose enable bit is also set, and the interrupt output equals that bit.
- R10: The controller write strobe fires on a port B write only when port B direction bits 5..3 equal 110. Its data is the updated port B value.
- R11: The flag set strobe bit k sets flag k on the next clock and wins over a clear in the same cycle.
- R12: Selects 2, 3, 11 and 12 store and return the port B direction, port A direction, auxiliary control and peripheral control bytes. These bytes also appear on output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 4 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current select |
| flag_set | input | 7 | Per-source interrupt flag set strobes |
| t1_count | input | 16 | Live timer 1 count |
| t2_count | input | 16 | Live timer 2 count |
| t1_load | output | 1 | Timer 1 start strobe |
| t1_load_val | output | 16 | Timer 1 start value |
| t2_load | output | 1 | Timer 2 start strobe |
| t2_load_val | output | 16 | Timer 2 start value |
| pa_q | output | 8 | Port A value |
| pa_dir | output | 8 | Port A direction (1 = output) |
| pb_q | output | 8 | Port B value |
| pb_dir | output | 8 | Port B direction (1 = output) |
| acr_q | output | 8 | Auxiliary control byte |
| pcr_q | output | 8 | Peripheral control byte |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_data | output | 8 | Port B value sent to the controller |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets port B writes under mixed direction masks. A design that ignored the mask would overwrite input bits, and the port B readback would differ. It checks the handshake pattern 110 against nearby patterns such as 111 and 010; a loose decode would strobe the controller too often. It drives flag set strobes in the same cycle as flag clears from reads, flag writes and timer loads; a design where the clear won would lose an event, and the flag byte would show it. It also checks the enable byte's set/clear write polarity and its forced top bit, and that the first timer loads use the 0xFF reset latches.

// File: rtl/via_regfile.sv
module via_regfile #(
  parameter int DW = 8,
  parameter int T1_BIT = 6,
  parameter int T2_BIT = 5,
  parameter int SR_BIT = 2,
  parameter logic [2:0] CTL_PAT = 3'b110
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      sel,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [DW-2:0]   flag_set,
  input  logic [2*DW-1:0] t1_count,
  input  logic [2*DW-1:0] t2_count,
  output logic            t1_load,
  output logic [2*DW-1:0] t1_load_val,
  output logic            t2_load,
  output logic [2*DW-1:0] t2_load_val,
  output logic [DW-1:0]   pa_q,
  output logic [DW-1:0]   pa_dir,
  output logic [DW-1:0]   pb_q,
  output logic [DW-1:0]   pb_dir,
  output logic [DW-1:0]   acr_q,
  output logic [DW-1:0]   pcr_q,
  output logic            ctl_wr,
  output logic [DW-1:0]   ctl_data,
  output logic            irq
);
  localparam int NF = DW - 1;
  localparam logic [3:0] S_PB = 4'd0, S_PA = 4'd1, S_DB = 4'd2, S_DA = 4'd3,
                         S_T1L = 4'd4, S_T1H = 4'd5, S_T1LL = 4'd6, S_T1LH = 4'd7,
                         S_T2L = 4'd8, S_T2H = 4'd9, S_SR = 4'd10, S_ACR = 4'd11,
                         S_PCR = 4'd12, S_IFR = 4'd13, S_IER = 4'd14, S_PA2 = 4'd15;

  logic [DW-1:0] pa, pb, ddra, ddrb, acr, pcr, sr, t1ll, t1lh, t2ll;
  logic [NF-1:0] flags, ier, clr;
  logic [DW-1:0] pb_next;

  wire wr_pb = wr_en && sel == S_PB;
  assign pb_next = (pb & ~ddrb) | (wdata & ddrb);

  always_comb begin
    clr = '0;
    if (wr_en) begin
      case (sel)
        S_T1H: clr[T1_BIT] = 1'b1;
        S_T2H: clr[T2_BIT] = 1'b1;
        S_SR:  clr[SR_BIT] = 1'b1;
        S_IFR: clr = wdata[NF-1:0];
        default: ;
      endcase
    end
    if (rd_en) begin
      case (sel)
        S_T1L: clr[T1_BIT] = 1'b1;
        S_T2L: clr[T2_BIT] = 1'b1;
        S_SR:  clr[SR_BIT] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa <= '0; pb <= '0; ddra <= '0; ddrb <= '0;
      acr <= '0; pcr <= '0; sr <= '0;
      t1ll <= '1; t1lh <= '1; t2ll <= '1;
      flags <= '0; ier <= '0;
    end else begin
      flags <= (flags & ~clr) | flag_set;
      if (wr_en) begin
        case (sel)
          S_PB:          pb <= pb_next;
          S_PA, S_PA2:   pa <= wdata;
          S_DB:          ddrb <= wdata;
          S_DA:          ddra <= wdata;
          S_T1L, S_T1LL: t1ll <= wdata;
          S_T1H, S_T1LH: t1lh <= wdata;
          S_T2L:         t2ll <= wdata;
          S_SR:          sr <= wdata;
          S_ACR:         acr <= wdata;
          S_PCR:         pcr <= wdata;
          S_IER:         ier <= wdata[DW-1] ? (ier | wdata[NF-1:0]) : (ier & ~wdata[NF-1:0]);
          default: ;
        endcase
      end
    end
  end

  wire any_irq = |(flags & ier);

  always_comb begin
    case (sel)
      S_PB:         rdata = pb;
      S_PA, S_PA2:  rdata = pa;
      S_DB:         rdata = ddrb;
      S_DA:         rdata = ddra;
      S_T1L:        rdata = t1_count[DW-1:0];
      S_T1H:        rdata = t1_count[2*DW-1:DW];
      S_T1LL:       rdata = t1ll;
      S_T1LH:       rdata = t1lh;
      S_T2L:        rdata = t2_count[DW-1:0];
      S_T2H:        rdata = t2_count[2*DW-1:DW];
      S_SR:         rdata = sr;
      S_ACR:        rdata = acr;
      S_PCR:        rdata = pcr;
      S_IFR:        rdata = {any_irq, flags};
      default:      rdata = {1'b1, ier};
    endcase
  end

  assign t1_load     = wr_en && sel == S_T1H;
  assign t1_load_val = {wdata, t1ll};
  assign t2_load     = wr_en && sel == S_T2H;
  assign t2_load_val = {wdata, t2ll};
  assign ctl_wr      = wr_pb && ddrb[5:3] == CTL_PAT;
  assign ctl_data    = pb_next;
  assign irq         = any_irq;
  assign pa_q = pa;
  assign pa_dir = ddra;
  assign pb_q = pb;
  assign pb_dir = ddrb;
  assign acr_q = acr;
  assign pcr_q = pcr;

  a_r3_inputs_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pb |=> ((pb ^ $past(pb)) & ~$past(ddrb)) == '0);
  a_r4_ier_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == S_IER && wdata[DW-1]) |=> (ier & $past(wdata[NF-1:0])) == $past(wdata[NF-1:0]));
  a_r5_ifr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == S_IFR && flag_set == '0) |=> (flags & $past(wdata[NF-1:0])) == '0);
  a_r6_sr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && sel == S_SR && !flag_set[SR_BIT]) |=> !flags[SR_BIT]);
  a_r7_t1_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == S_T1L && !flag_set[T1_BIT]) |=> !flags[T1_BIT]);
  a_r10_ctl_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> (wr_en && sel == S_PB && pb_dir[5:3] == CTL_PAT));
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> (flags & $past(flag_set)) == $past(flag_set));
endmodule

// File: tb/via_regfile_test.sv
module via_regfile_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] sel = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [6:0] flag_set = 0;
  logic [15:0] t1_count = 16'h1234, t2_count = 16'hABCD;
  logic t1_load, t2_load, ctl_wr, irq;
  logic [15:0] t1_load_val, t2_load_val;
  logic [7:0] pa_q, pa_dir, pb_q, pb_dir, acr_q, pcr_q, ctl_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  via_regfile uut (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .flag_set(flag_set), .t1_count(t1_count), .t2_count(t2_count),
    .t1_load(t1_load), .t1_load_val(t1_load_val), .t2_load(t2_load), .t2_load_val(t2_load_val),
    .pa_q(pa_q), .pa_dir(pa_dir), .pb_q(pb_q), .pb_dir(pb_dir), .acr_q(acr_q), .pcr_q(pcr_q),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .irq(irq));

  int m_pa, m_pb, m_da, m_db, m_acr, m_pcr, m_sr, m_t1ll, m_t1lh, m_t2ll, m_ifr, m_ier;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pa = 0; m_pb = 0; m_da = 0; m_db = 0; m_acr = 0; m_pcr = 0; m_sr = 0;
      m_t1ll = 255; m_t1lh = 255; m_t2ll = 255; m_ifr = 0; m_ier = 0;
    end else begin
      int c;
      c = 0;
      if (wr_en) begin
        case (int'(sel))
          0: m_pb = ((m_pb & ~m_db) | (int'(wdata) & m_db)) & 255;
          1, 15: m_pa = wdata;
          2: m_db = wdata;
          3: m_da = wdata;
          4, 6: m_t1ll = wdata;
          5: begin m_t1lh = wdata; c = c | 64; end
          7: m_t1lh = wdata;
          8: m_t2ll = wdata;
          9: c = c | 32;
          10: begin m_sr = wdata; c = c | 4; end
          11: m_acr = wdata;
          12: m_pcr = wdata;
          13: c = c | (int'(wdata) & 127);
          default: m_ier = wdata[7] ? (m_ier | (int'(wdata) & 127)) : (m_ier & ~int'(wdata) & 127);
        endcase
      end
      if (rd_en) begin
        if (sel == 4) c = c | 64;
        if (sel == 8) c = c | 32;
        if (sel == 10) c = c | 4;
      end
      m_ifr = ((m_ifr & ~c) | int'(flag_set)) & 127;
    end
  end

  function automatic int exp_rd(int s);
    case (s)
      0: return m_pb;
      1, 15: return m_pa;
      2: return m_db;
      3: return m_da;
      4: return t1_count & 255;
      5: return t1_count >> 8;
      6: return m_t1ll;
      7: return m_t1lh;
      8: return t2_count & 255;
      9: return t2_count >> 8;
      10: return m_sr;
      11: return m_acr;
      12: return m_pcr;
      13: return ((m_ifr & m_ier) != 0 ? 128 : 0) | m_ifr;
      default: return 128 | m_ier;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R3";
      1, 15: return "R2";
      4, 5, 8, 9: return "R7";
      6, 7: return "R8";
      10: return "R6";
      13: return "R9";
      14: return "R4";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk("R2", pa_q, m_pa);
    chk("R3", pb_q, m_pb);
    chk("R12", pa_dir, m_da);
    chk("R12", pb_dir, m_db);
    chk("R12", acr_q, m_acr);
    chk("R12", pcr_q, m_pcr);
    chk("R9", irq, (m_ifr & m_ier) != 0);
  endtask

  task automatic step(int s, bit w, bit r, int d, int f);
    bit ec;
    @(negedge clk);
    check_regs();
    sel = 4'(s); wr_en = w; rd_en = r; wdata = 8'(d); flag_set = 7'(f);
    t1_count = 16'($urandom); t2_count = 16'($urandom);
    #1;
    chk(tag_of(s), rdata, exp_rd(s));
    chk("R8", t1_load, w && s == 5);
    chk("R8", t2_load, w && s == 9);
    if (w && s == 5) chk("R8", t1_load_val, (d << 8) | m_t1ll);
    if (w && s == 9) chk("R8", t2_load_val, (d << 8) | m_t2ll);
    ec = w && s == 0 && ((m_db >> 3) & 7) == 6;
    chk("R10", ctl_wr, ec);
    if (ec) chk("R10", ctl_data, ((m_pb & ~m_db) | (d & m_db)) & 255);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    step(6, 0, 1, 0, 0);
    step(7, 0, 1, 0, 0);
    step(14, 0, 1, 0, 0);
    step(13, 0, 1, 0, 0);
    step(9, 1, 0, 8'h12, 0);        // R1 timer 2 latch 0xFF in load value
    // R2 alias
    step(1, 1, 0, 8'h5A, 0); step(15, 0, 1, 0, 0);
    step(15, 1, 0, 8'hC3, 0); step(1, 0, 1, 0, 0);
    // R3 masked port B
    step(2, 1, 0, 8'h0F, 0); step(0, 1, 0, 8'hFF, 0); step(0, 0, 1, 0, 0);
    step(2, 1, 0, 8'hF0, 0); step(0, 1, 0, 8'h00, 0); step(0, 0, 1, 0, 0);
    // R10 handshake pattern
    step(2, 1, 0, 8'h30, 0); step(0, 1, 0, 8'hAA, 0);
    step(2, 1, 0, 8'h38, 0); step(0, 1, 0, 8'h55, 0);
    step(2, 1, 0, 8'h10, 0); step(0, 1, 0, 8'h55, 0);
    // R4 / R9 / R11 / R5 interrupts
    step(14, 1, 0, 8'hC4, 7'h44); step(14, 0, 1, 0, 0); step(13, 0, 1, 0, 0);
    step(14, 1, 0, 8'h04, 0); step(13, 0, 1, 0, 0);
    step(13, 1, 0, 8'h40, 7'h40);   // R11 set beats clear
    step(13, 1, 0, 8'h7F, 0); step(13, 0, 1, 0, 0);
    // R6 / R7 / R8 flag clears
    step(0, 0, 0, 0, 7'h64); step(10, 1, 0, 8'h9C, 0); step(10, 0, 1, 0, 0);
    step(4, 0, 1, 0, 0); step(8, 0, 1, 0, 0);
    step(0, 0, 0, 0, 7'h60); step(4, 1, 0, 8'h34, 0); step(5, 1, 0, 8'h12, 0);
    step(9, 1, 0, 8'h77, 0); step(8, 1, 0, 8'h21, 7'h20); step(9, 1, 0, 8'h43, 0);
    // R12 control bytes
    step(11, 1, 0, 8'hE1, 0); step(12, 1, 0, 8'h3C, 0); step(3, 1, 0, 8'h81, 0);
    step(11, 0, 1, 0, 0); step(12, 0, 1, 0, 0); step(3, 0, 1, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int s, op;
      s = $urandom_range(0, 15);
      op = $urandom_range(0, 2);
      step(s, op == 1, op == 2, $urandom_range(0, 255),
           ($urandom_range(0, 3) == 0) ? $urandom_range(0, 127) : 0);
    end
    @(negedge clk);
    check_regs();
    done = 1;
    summary();
    $finish;
  end
endmodule